// File: doc/BRIEF.md
# Double-Buffered Setting Commit and Profile Select

This block decides when newly written synthesis settings take effect. A register-write port fills a bank of buffered entries, one per profile, each holding a frequency tuning word, a phase offset and an amplitude scale. The active settings that feed the synthesis channels are loaded from the bank only when a commit event occurs. Until then they do not change.

A commit event is either a rising edge on the update strobe or any change in the value on the profile-select pins. Both inputs are sampled only on the rising edge of a synchronization clock. That clock is the system clock divided by a parameter (four by default) and is driven out so that external logic can time its strobes against it. A detected event produces a single-cycle commit pulse one system clock after the sampling edge. The active registers then load the entry that the sampled profile value selects. Because sampling, detection and loading each happen on fixed edges, the latency from the strobe to the output is fixed.

Top module: `ddsUpdTop`

## Requirements
- R1: While master reset is high and in the first cycle after it falls, every bank entry and the active outputs hold frequency 0, phase 0 and amplitude all-ones, and syncClk is high.
- R2: syncClk is high for DIV/2 system cycles and low for DIV/2 system cycles. Its rising edge is the system edge at which profile and update inputs are sampled.
- R3: A register write changes only the bank entry it addresses. The active outputs change only on the system edge that ends a commitPulse cycle.
- R4: An update input sampled high at a syncClk rising edge, after it was sampled low at the previous one, raises commitPulse for the system cycle that follows that edge. The active outputs show the new values one cycle later.
- R5: A profile-select value sampled at a syncClk rising edge that differs from the value sampled at the previous one causes the same commit as R4.
- R6: A commit loads the active outputs from the bank entry whose index equals the profile value sampled at the triggering edge.
- R7: An update edge and a profile change seen at the same sampling edge produce exactly one commitPulse.
- R8: An update strobe held high across several sampling edges commits once. A profile glitch that starts and ends between two sampling edges causes no commit.
- R9: Write field codes are 0 for frequency, 1 for phase (low PHASE_W bits of the data) and 2 for amplitude (low AMP_W bits). A write with code 3 changes no entry.
- R10: commitPulse is never high for two cycles in a row. It is high only in the system cycle right after a syncClk rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| masterRst | input | 1 | Active-high reset to defaults |
| updIn | input | 1 | Update strobe, sampled on syncClk rise |
| profIn | input | PROF_W | Profile select, sampled on syncClk rise |
| wrEn | input | 1 | Bank write enable |
| wrField | input | 2 | Field code of the write (see R9) |
| wrProf | input | PROF_W | Bank entry addressed by the write |
| wrData | input | FREQ_W | Write data |
| syncClk | output | 1 | Divided synchronization clock |
| commitPulse | output | 1 | One-cycle commit indication |
| actFreq | output | FREQ_W | Active frequency tuning word |
| actPhase | output | PHASE_W | Active phase offset |
| actAmp | output | AMP_W | Active amplitude scale |

## Verification
Several properties are checked on every cycle: the period of syncClk, that commitPulse lasts one cycle and follows a syncClk rise, that the active outputs hold steady outside a commit, and the reset defaults. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers which entry a commit loads, that a held strobe or a simultaneous strobe and profile change commits only once, that a glitch between sampling edges is missed, and that a field code of 3 is ignored.

// File: rtl/ddsUpdPkg.sv
package ddsUpdPkg;
  localparam int PROF_W = 4;

  typedef enum logic [1:0] {
    FLD_FREQ  = 2'd0,
    FLD_PHASE = 2'd1,
    FLD_AMP   = 2'd2,
    FLD_NONE  = 2'd3
  } fieldSel_e;

  typedef struct packed {
    logic              commit;
    logic [PROF_W-1:0] profSel;
  } updStrobe_t;
endpackage

// File: rtl/updTiming.sv
module updTiming
  import ddsUpdPkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              updIn,
  input  logic [PROF_W-1:0] profIn,
  output logic              syncClk,
  output updStrobe_t        strobe
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0]     divCnt, divNext;
  logic              sampleTick;
  logic              syncQ;
  logic              updPrev;
  logic [PROF_W-1:0] profQ;
  logic              pendQ;
  logic              eventSeen;

  assign sampleTick = (divCnt == CW'(DIV - 1));
  assign divNext    = sampleTick ? '0 : divCnt + 1'b1;
  assign eventSeen  = (updIn & ~updPrev) | (profIn != profQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      syncQ  <= 1'b1;
    end else begin
      divCnt <= divNext;
      syncQ  <= (divNext < CW'(HALF));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      updPrev <= 1'b0;
      profQ   <= '0;
      pendQ   <= 1'b0;
    end else begin
      pendQ <= sampleTick & eventSeen;
      if (sampleTick) begin
        updPrev <= updIn;
        profQ   <= profIn;
      end
    end
  end

  assign syncClk        = syncQ;
  assign strobe.commit  = pendQ;
  assign strobe.profSel = profQ;
endmodule

// File: rtl/profBank.sv
module profBank
  import ddsUpdPkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [1:0]         wrField,
  input  logic [PROF_W-1:0]  wrProf,
  input  logic [FREQ_W-1:0]  wrData,
  input  updStrobe_t         strobe,
  output logic [FREQ_W-1:0]  actFreq,
  output logic [PHASE_W-1:0] actPhase,
  output logic [AMP_W-1:0]   actAmp
);
  localparam int NPROF = 1 << PROF_W;

  logic [FREQ_W-1:0]  freqTbl  [NPROF];
  logic [PHASE_W-1:0] phaseTbl [NPROF];
  logic [AMP_W-1:0]   ampTbl   [NPROF];

  for (genvar p = 0; p < NPROF; p++) begin : g_entry
    logic [FREQ_W-1:0]  freqQ;
    logic [PHASE_W-1:0] phaseQ;
    logic [AMP_W-1:0]   ampQ;
    logic               hit;

    assign hit = wrEn && (wrProf == PROF_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        freqQ  <= '0;
        phaseQ <= '0;
        ampQ   <= '1;
      end else if (hit) begin
        case (fieldSel_e'(wrField))
          FLD_FREQ:  freqQ  <= wrData;
          FLD_PHASE: phaseQ <= wrData[PHASE_W-1:0];
          FLD_AMP:   ampQ   <= wrData[AMP_W-1:0];
          default:   ;
        endcase
      end
    end

    assign freqTbl[p]  = freqQ;
    assign phaseTbl[p] = phaseQ;
    assign ampTbl[p]   = ampQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actFreq  <= '0;
      actPhase <= '0;
      actAmp   <= '1;
    end else if (strobe.commit) begin
      actFreq  <= freqTbl[strobe.profSel];
      actPhase <= phaseTbl[strobe.profSel];
      actAmp   <= ampTbl[strobe.profSel];
    end
  end
endmodule

// File: rtl/ddsUpdTop.sv
module ddsUpdTop
  import ddsUpdPkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 10,
  parameter int DIV     = 4
) (
  input  logic               clk,
  input  logic               masterRst,
  input  logic               updIn,
  input  logic [PROF_W-1:0]  profIn,
  input  logic               wrEn,
  input  logic [1:0]         wrField,
  input  logic [PROF_W-1:0]  wrProf,
  input  logic [FREQ_W-1:0]  wrData,
  output logic               syncClk,
  output logic               commitPulse,
  output logic [FREQ_W-1:0]  actFreq,
  output logic [PHASE_W-1:0] actPhase,
  output logic [AMP_W-1:0]   actAmp
);
  updStrobe_t strobe;

  updTiming #(.DIV(DIV)) timing_i (
    .clk     (clk),
    .rst     (masterRst),
    .updIn   (updIn),
    .profIn  (profIn),
    .syncClk (syncClk),
    .strobe  (strobe)
  );

  profBank #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W)) bank_i (
    .clk      (clk),
    .rst      (masterRst),
    .wrEn     (wrEn),
    .wrField  (wrField),
    .wrProf   (wrProf),
    .wrData   (wrData),
    .strobe   (strobe),
    .actFreq  (actFreq),
    .actPhase (actPhase),
    .actAmp   (actAmp)
  );

  assign commitPulse = strobe.commit;
endmodule

// File: rtl/ddsUpdChk.sv
module ddsUpdChk #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 10,
  parameter int DIV     = 4
) (
  input logic               clk,
  input logic               masterRst,
  input logic               syncClk,
  input logic               commitPulse,
  input logic [FREQ_W-1:0]  actFreq,
  input logic [PHASE_W-1:0] actPhase,
  input logic [AMP_W-1:0]   actAmp
);
  logic        seenRise;
  int unsigned gapCnt;

  always_ff @(posedge clk) begin
    if (masterRst) begin
      seenRise <= 1'b0;
      gapCnt   <= 0;
    end else if (syncClk && !$past(syncClk)) begin
      seenRise <= 1'b1;
      gapCnt   <= 1;
    end else begin
      gapCnt <= gapCnt + 1;
    end
  end

  // R2: rising edges of syncClk are DIV system cycles apart
  a_r2_sync_period: assert property (@(posedge clk) disable iff (masterRst)
    (seenRise && syncClk && !$past(syncClk) && !$past(masterRst)) |-> (gapCnt == DIV));

  // R10: commit pulse lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (masterRst)
    commitPulse |=> !commitPulse);

  // R10: commit pulse follows a syncClk rise
  a_r10_after_rise: assert property (@(posedge clk) disable iff (masterRst)
    (commitPulse && !$past(masterRst)) |-> (syncClk && !$past(syncClk)));

  // R3: active outputs hold unless the previous cycle carried a commit
  a_r3_hold: assert property (@(posedge clk) disable iff (masterRst)
    (!$past(masterRst) && !$past(commitPulse)) |->
      ($stable(actFreq) && $stable(actPhase) && $stable(actAmp)));

  // R1: defaults in the first cycle after reset
  a_r1_defaults: assert property (@(posedge clk) disable iff (masterRst)
    $past(masterRst) |-> (actFreq == '0 && actPhase == '0 && actAmp == '1 && syncClk));
endmodule

bind ddsUpdTop ddsUpdChk #(
  .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W), .DIV(DIV)
) chk_i (
  .clk         (clk),
  .masterRst   (masterRst),
  .syncClk     (syncClk),
  .commitPulse (commitPulse),
  .actFreq     (actFreq),
  .actPhase    (actPhase),
  .actAmp      (actAmp)
);

// File: tb/ddsUpdTop_tb.sv
module ddsUpdTop_tb_top;
  localparam int FW = 32, PW = 14, AW = 10, DV = 4;

  logic          clk = 1'b0;
  logic          masterRst = 1'b1;
  logic          updIn = 1'b0;
  logic [3:0]    profIn = '0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrField = '0;
  logic [3:0]    wrProf = '0;
  logic [FW-1:0] wrData = '0;
  logic          syncClk, commitPulse;
  logic [FW-1:0] actFreq;
  logic [PW-1:0] actPhase;
  logic [AW-1:0] actAmp;

  int errors = 0, checks = 0, commits = 0, cycles = 0;

  ddsUpdTop #(.FREQ_W(FW), .PHASE_W(PW), .AMP_W(AW), .DIV(DV)) dut_i (
    .clk(clk), .masterRst(masterRst), .updIn(updIn), .profIn(profIn),
    .wrEn(wrEn), .wrField(wrField), .wrProf(wrProf), .wrData(wrData),
    .syncClk(syncClk), .commitPulse(commitPulse),
    .actFreq(actFreq), .actPhase(actPhase), .actAmp(actAmp)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int            mPhaseCnt;
  bit            mSync, mPend, mUpdLast;
  int            mProfLast;
  logic [FW-1:0] mFreq [16];
  logic [PW-1:0] mPhase [16];
  logic [AW-1:0] mAmp [16];
  logic [FW-1:0] mActF;
  logic [PW-1:0] mActP;
  logic [AW-1:0] mActA;

  always @(posedge clk) begin
    if (masterRst) begin
      mPhaseCnt = 0; mSync = 1; mPend = 0; mUpdLast = 0; mProfLast = 0;
      for (int i = 0; i < 16; i++) begin mFreq[i] = 0; mPhase[i] = 0; mAmp[i] = '1; end
      mActF = 0; mActP = 0; mActA = '1;
    end else begin
      bit trig;
      if (mPend) begin
        mActF = mFreq[mProfLast]; mActP = mPhase[mProfLast]; mActA = mAmp[mProfLast];
      end
      trig = 0;
      if (mPhaseCnt == DV - 1) begin
        trig = (updIn && !mUpdLast) || (int'(profIn) != mProfLast);
        mUpdLast = updIn;
        mProfLast = int'(profIn);
      end
      mPend = trig;
      if (wrEn) begin
        if (wrField == 2'd0) mFreq[wrProf] = wrData;
        else if (wrField == 2'd1) mPhase[wrProf] = wrData[PW-1:0];
        else if (wrField == 2'd2) mAmp[wrProf] = wrData[AW-1:0];
      end
      mPhaseCnt = (mPhaseCnt + 1) % DV;
      mSync = (mPhaseCnt < DV / 2);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (commitPulse === 1'b1) commits++;
    chk("R2 syncClk", 32'(syncClk), 32'(mSync));
    chk("R10 commitPulse", 32'(commitPulse), 32'(mPend));
    chk("R6 actFreq", actFreq, mActF);
    chk("R6 actPhase", 32'(actPhase), 32'(mActP));
    chk("R6 actAmp", 32'(actAmp), 32'(mActA));
  end

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      finishRun();
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] f, input logic [3:0] p, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrField = f; wrProf = p; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic expectAct(input string req, input logic [31:0] f, input logic [13:0] p,
                           input logic [9:0] a);
    chk(req, actFreq, f);
    chk(req, 32'(actPhase), 32'(p));
    chk(req, 32'(actAmp), 32'(a));
  endtask

  initial begin
    int base;
    waitCyc(5);
    expectAct("R1 reset defaults", 32'h0, 14'h0, 10'h3FF);
    chk("R1 syncClk in reset", 32'(syncClk), 32'h1);
    masterRst = 0;
    @(negedge clk);
    expectAct("R1 after reset", 32'h0, 14'h0, 10'h3FF);

    writeReg(2'd0, 4'd0, 32'h1234_5678);
    writeReg(2'd1, 4'd0, 32'h0000_0ABC);
    writeReg(2'd2, 4'd0, 32'h0000_0155);
    writeReg(2'd0, 4'd5, 32'hDEAD_BEEF);
    writeReg(2'd1, 4'd5, 32'h0000_3FFF);
    writeReg(2'd2, 4'd5, 32'h0000_00F0);
    writeReg(2'd0, 4'd9, 32'h0000_0100);
    writeReg(2'd1, 4'd9, 32'h0000_0001);
    writeReg(2'd2, 4'd9, 32'h0000_0200);
    waitCyc(10);
    expectAct("R3 writes not yet active", 32'h0, 14'h0, 10'h3FF);
    chk("R3 no commit without event", commits, 0);

    // R4 and R8: long update strobe -> one commit, profile 0 loaded
    base = commits;
    updIn = 1; waitCyc(12); updIn = 0; waitCyc(8);
    chk("R8 held strobe commits once", commits - base, 1);
    expectAct("R4 update loads profile 0", 32'h1234_5678, 14'h0ABC, 10'h155);

    // R5 and R6: profile change alone
    base = commits;
    profIn = 4'd5; waitCyc(10);
    chk("R5 profile change commits", commits - base, 1);
    expectAct("R6 profile 5 loaded", 32'hDEAD_BEEF, 14'h3FFF, 10'h0F0);

    // R9: field code 3 ignored
    writeReg(2'd3, 4'd5, 32'h0000_0000);
    base = commits;
    updIn = 1; waitCyc(6); updIn = 0; waitCyc(8);
    chk("R9 commit after ignored write", commits - base, 1);
    expectAct("R9 code 3 wrote nothing", 32'hDEAD_BEEF, 14'h3FFF, 10'h0F0);

    // R7: simultaneous update edge and profile change
    base = commits;
    profIn = 4'd9; updIn = 1; waitCyc(8); updIn = 0; waitCyc(8);
    chk("R7 single commit", commits - base, 1);
    expectAct("R7 profile 9 loaded", 32'h0000_0100, 14'h0001, 10'h200);

    // R8: glitch between sampling edges
    base = commits;
    @(posedge syncClk);
    @(negedge clk); profIn = 4'd7;
    @(negedge clk); profIn = 4'd9;
    waitCyc(10);
    chk("R8 glitch ignored", commits - base, 0);
    expectAct("R8 outputs unchanged", 32'h0000_0100, 14'h0001, 10'h200);

    // R3: buffered write takes effect only at commit
    writeReg(2'd0, 4'd9, 32'hCAFE_0001);
    waitCyc(8);
    chk("R3 buffer only", actFreq, 32'h0000_0100);
    updIn = 1; waitCyc(6); updIn = 0; waitCyc(8);
    chk("R3 committed value", actFreq, 32'hCAFE_0001);

    finishRun();
  end
endmodule